// File: doc/BRIEF.md
# Framed Synchronous Serial Port Channel

This block is one full-duplex channel of a synchronous serial port. It divides the system clock down to a serial clock and issues a one-bit-period frame pulse from an internal interval divider. After each pulse it shifts a word of 3 to 32 bits out on `sdo` and, in the same bit periods, captures a word of the same length from `sdi`. On the host side it has a two-entry transmit queue and a two-entry receive queue.

Two framing policies exist. In the data-driven policy a frame is issued only when the transmit queue holds a word, so a single host write is enough to start a transfer. In the free-running policy frames keep their schedule whatever the queues hold. In that policy an empty transmit queue makes the channel send the last word again and set a sticky underflow flag. A word that arrives while the receive queue is full is dropped, the queued words are kept, and a sticky overflow flag is set. The host clears each flag by pulsing its clear input.

Top module: `sport_chan`

## Requirements
- R1: The word length is `cfg_wlen_m1` + 1 bits (valid field values 2 to 31). Each frame pulse is followed by exactly that many data bits.
- R2: With `cfg_lsb_first` = 0 the first bit on `sdo` is word bit L-1 (MSB first). With `cfg_lsb_first` = 1 the first bit is bit 0.
- R3: `fs` is high for exactly one serial clock period, the period just before the first data bit, and is low during the data bits. `sdo` and `fs` change only when `sclk` falls, and `sdi` is sampled when `sclk` rises.
- R4: The `sclk` period is 2 × `cfg_half_div` system clock cycles.
- R5: When frames are back to back, consecutive rising edges of `fs` are (`cfg_fs_gap` + 1) serial clock periods apart.
- R6: With `cfg_free_fs` = 0 no frame starts while the transmit queue is empty, and one write to an empty queue starts a frame.
- R7: With `cfg_free_fs` = 1 frames keep their schedule. A frame that finds the transmit queue empty re-sends the previously sent word in the bit order selected at that moment and sets `tx_uf`.
- R8: The transmit queue holds two words in write order. `tx_full` is high when it holds two, and a write while full is ignored.
- R9: Each received word enters a two-entry receive queue. `rx_valid` flags a queued word, `rx_data` shows the oldest one, and a pulse on `rx_rd` removes it.
- R10: A word that completes while the receive queue holds two words sets `rx_ovf` and is discarded. The two queued words are unchanged.
- R11: `tx_uf` and `rx_ovf` stay set until a one-cycle pulse on `clr_tx_uf` or `clr_rx_ovf` clears them.
- R12: While `cfg_en` = 0, `sclk`, `fs` and `sdo` are held low and no frame runs. The queue contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Channel enable |
| cfg_free_fs | input | 1 | 1: free-running frames, 0: data-driven frames |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_wlen_m1 | input | 5 | Word length minus one |
| cfg_half_div | input | DIV_W | Serial clock half period in system clocks |
| cfg_fs_gap | input | FS_W | Frame interval minus one, in serial clock periods |
| tx_wr | input | 1 | Transmit word write strobe |
| tx_data | input | 32 | Transmit word |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Receive queue pop strobe |
| rx_data | output | 32 | Oldest received word |
| rx_valid | output | 1 | Receive queue not empty |
| clr_tx_uf | input | 1 | Clear underflow flag |
| clr_rx_ovf | input | 1 | Clear overflow flag |
| tx_uf | output | 1 | Sticky transmit underflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| sclk | output | 1 | Serial clock |
| fs | output | 1 | Frame pulse |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The assertions check the invariants that hold on every cycle:
- `fs` and `sdo` move only on falling `sclk`.
- A frame pulse never lasts past one period.
- In the data-driven policy no frame starts from an empty queue.
- The two flags stay set until cleared, and underflow appears only together with a frame pulse.
- `rx_valid` drops only after a pop.

Only the bench scenarios can show the remaining behaviour:
- Word values and bit order at the extreme lengths.
- The exact serial clock period and frame spacing.
- Re-sending of the previous word after a change of bit order.
- Which word survives an overflow.
- The dropped write to a full transmit queue.

// File: rtl/sport_chan.sv
module sport_chan #(
  parameter int DIV_W = 8,
  parameter int FS_W  = 12,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_free_fs,
  input  logic             cfg_lsb_first,
  input  logic [4:0]       cfg_wlen_m1,
  input  logic [DIV_W-1:0] cfg_half_div,
  input  logic [FS_W-1:0]  cfg_fs_gap,
  input  logic             tx_wr,
  input  logic [31:0]      tx_data,
  output logic             tx_full,
  input  logic             rx_rd,
  output logic [31:0]      rx_data,
  output logic             rx_valid,
  input  logic             clr_tx_uf,
  input  logic             clr_rx_ovf,
  output logic             tx_uf,
  output logic             rx_ovf,
  output logic             sclk,
  output logic             fs,
  output logic             sdo,
  input  logic             sdi
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [DIV_W-1:0] hc;
  logic [DIV_W:0]   hc_nx;
  logic             sclk_q, fs_q, sdo_q;
  logic [FS_W-1:0]  gap;
  logic             pend, in_bits;
  logic [4:0]       bidx;
  logic [31:0]      tword, rsh, rx_word, next_word;
  logic [31:0]      tmem [DEPTH];
  logic [31:0]      rmem [DEPTH];
  logic [AW-1:0]    trp, twp, rrp, rwp;
  logic [CW-1:0]    tcnt, rcnt;
  logic             tx_uf_q, rx_ovf_q;

  function automatic logic [4:0] bpos(input logic [4:0] i);
    return cfg_lsb_first ? i : cfg_wlen_m1 - i;
  endfunction

  assign hc_nx = {1'b0, hc} + (DIV_W+1)'(1);
  wire tick   = cfg_en && (hc_nx >= {1'b0, cfg_half_div});
  wire fall_e = tick && sclk_q;
  wire rise_e = tick && !sclk_q;

  wire tx_any = (tcnt != '0);
  wire start  = fall_e && (gap == '0) && (cfg_free_fs || tx_any);
  wire twr_ok = tx_wr && (tcnt != CW'(DEPTH));
  wire tpop   = start && tx_any;
  wire rdone  = rise_e && in_bits && (bidx == cfg_wlen_m1);
  wire rfull  = (rcnt == CW'(DEPTH));
  wire rpush  = rdone && !rfull;
  wire rpop   = rx_rd && (rcnt != '0);

  assign next_word = tx_any ? tmem[trp] : tword;

  always_comb begin
    rx_word = rsh;
    rx_word[bpos(bidx)] = sdi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0; sclk_q <= 1'b0;
    end else if (!cfg_en) begin
      hc <= '0; sclk_q <= 1'b0;
    end else if (tick) begin
      hc <= '0; sclk_q <= !sclk_q;
    end else begin
      hc <= hc_nx[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0; pend <= 1'b0; in_bits <= 1'b0; bidx <= '0;
      fs_q <= 1'b0; sdo_q <= 1'b0; tword <= '0; rsh <= '0;
    end else if (!cfg_en) begin
      gap <= '0; pend <= 1'b0; in_bits <= 1'b0;
      fs_q <= 1'b0; sdo_q <= 1'b0;
    end else begin
      if (fall_e) begin
        if (start) begin
          fs_q <= 1'b1; pend <= 1'b1; in_bits <= 1'b0; sdo_q <= 1'b0;
          gap <= cfg_fs_gap; tword <= next_word; rsh <= '0;
        end else begin
          fs_q <= 1'b0;
          if (gap != '0) gap <= gap - FS_W'(1);
          if (pend) begin
            pend <= 1'b0; in_bits <= 1'b1; bidx <= '0;
            sdo_q <= tword[bpos(5'd0)];
          end else if (in_bits) begin
            if (bidx == cfg_wlen_m1) begin
              in_bits <= 1'b0; sdo_q <= 1'b0;
            end else begin
              bidx  <= bidx + 5'd1;
              sdo_q <= tword[bpos(bidx + 5'd1)];
            end
          end
        end
      end
      if (rise_e && in_bits) rsh <= rx_word;
    end
  end

  always_ff @(posedge clk) begin
    if (twr_ok) tmem[twp] <= tx_data;
    if (rpush)  rmem[rwp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trp <= '0; twp <= '0; tcnt <= '0;
      rrp <= '0; rwp <= '0; rcnt <= '0;
      tx_uf_q <= 1'b0; rx_ovf_q <= 1'b0;
    end else begin
      if (twr_ok) twp <= twp + AW'(1);
      if (tpop)   trp <= trp + AW'(1);
      case ({twr_ok, tpop})
        2'b10:   tcnt <= tcnt + CW'(1);
        2'b01:   tcnt <= tcnt - CW'(1);
        default: tcnt <= tcnt;
      endcase
      if (rpush) rwp <= rwp + AW'(1);
      if (rpop)  rrp <= rrp + AW'(1);
      case ({rpush, rpop})
        2'b10:   rcnt <= rcnt + CW'(1);
        2'b01:   rcnt <= rcnt - CW'(1);
        default: rcnt <= rcnt;
      endcase
      tx_uf_q  <= (tx_uf_q && !clr_tx_uf) || (start && !tx_any);
      rx_ovf_q <= (rx_ovf_q && !clr_rx_ovf) || (rdone && rfull);
    end
  end

  assign tx_full  = (tcnt == CW'(DEPTH));
  assign rx_valid = (rcnt != '0);
  assign rx_data  = rmem[rrp];
  assign tx_uf    = tx_uf_q;
  assign rx_ovf   = rx_ovf_q;
  assign sclk     = sclk_q;
  assign fs       = fs_q;
  assign sdo      = sdo_q;
endmodule

// File: rtl/sport_chan_chk.sv
module sport_chan_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic cfg_free_fs,
  input logic sclk,
  input logic fs,
  input logic sdo,
  input logic tx_any,
  input logic tx_uf,
  input logic clr_tx_uf,
  input logic rx_ovf,
  input logic clr_rx_ovf,
  input logic rx_valid,
  input logic rx_rd
);
  // R3
  fs_one_period_chk: assert property (@(posedge clk) disable iff (!rst_n || !cfg_en)
    ($fell(sclk) && $past(fs)) |-> !fs);

  // R3
  sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n || !cfg_en)
    !$fell(sclk) |-> $stable(sdo));

  // R3
  fs_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n || !cfg_en)
    !$fell(sclk) |-> $stable(fs));

  // R6
  dep_wait_chk: assert property (@(posedge clk) disable iff (!rst_n || !cfg_en)
    ($rose(fs) && !cfg_free_fs) |-> $past(tx_any));

  // R7
  uf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_uf) |-> $rose(fs));

  // R11
  uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_uf) && !$past(clr_tx_uf)) |-> tx_uf);

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_ovf) && !$past(clr_rx_ovf)) |-> rx_ovf);

  // R9
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_valid) |-> $past(rx_rd));
endmodule

bind sport_chan sport_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_free_fs(cfg_free_fs),
  .sclk(sclk), .fs(fs), .sdo(sdo), .tx_any(tx_any),
  .tx_uf(tx_uf), .clr_tx_uf(clr_tx_uf), .rx_ovf(rx_ovf), .clr_rx_ovf(clr_rx_ovf),
  .rx_valid(rx_valid), .rx_rd(rx_rd)
);

// File: tb/sim_sport_chan.sv
`timescale 1ns/1ps
module sim_sport_chan;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, cfg_en = 1'b0, cfg_free_fs = 1'b0, cfg_lsb_first = 1'b0;
  logic [4:0]  cfg_wlen_m1 = 5'd7;
  logic [7:0]  cfg_half_div = 8'd2;
  logic [11:0] cfg_fs_gap = 12'd40;
  logic        tx_wr = 1'b0, rx_rd = 1'b0, clr_tx_uf = 1'b0, clr_rx_ovf = 1'b0;
  logic [31:0] tx_data = '0;
  logic        tx_full, rx_valid, tx_uf, rx_ovf, sclk, fs, sdo, sdi;
  logic [31:0] rx_data;

  assign sdi = sdo;

  sport_chan u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_free_fs(cfg_free_fs),
    .cfg_lsb_first(cfg_lsb_first), .cfg_wlen_m1(cfg_wlen_m1),
    .cfg_half_div(cfg_half_div), .cfg_fs_gap(cfg_fs_gap),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid),
    .clr_tx_uf(clr_tx_uf), .clr_rx_ovf(clr_rx_ovf), .tx_uf(tx_uf), .rx_ovf(rx_ovf),
    .sclk(sclk), .fs(fs), .sdo(sdo), .sdi(sdi)
  );

  int errs = 0, checks = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  function automatic logic [31:0] wmask(input int len);
    return (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_tx(input logic [31:0] w);
    @(negedge clk); tx_wr = 1'b1; tx_data = w;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pop_rx(output logic [31:0] w);
    @(negedge clk); w = rx_data; rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic grab(output logic [31:0] w, output logic first, output realtime t_fs);
    int len;
    int fs_in_bits;
    len = int'(cfg_wlen_m1) + 1;
    fs_in_bits = 0;
    do @(posedge sclk); while (fs !== 1'b1);
    t_fs = $realtime;
    w = '0;
    first = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(posedge sclk);
      if (i == 0) first = sdo;
      if (fs) fs_in_bits++;
      if (cfg_lsb_first) w[i] = sdo;
      else w = {w[30:0], sdo};
    end
    chk("R3", "fs low during data bits", fs_in_bits, 0);
  endtask

  task automatic set_cfg(input int len, input logic lsb, input logic free, input int gap);
    @(negedge clk);
    cfg_en = 1'b0;
    @(negedge clk);
    cfg_wlen_m1 = 5'(len - 1);
    cfg_lsb_first = lsb;
    cfg_free_fs = free;
    cfg_fs_gap = 12'(gap);
  endtask

  task automatic t_reset();
    idle(2);
    chk("R12", "sclk/fs/sdo in reset", {sclk, fs, sdo}, 0);
    chk("R8", "tx_full in reset", tx_full, 0);
    chk("R9", "rx_valid in reset", rx_valid, 0);
    chk("R11", "flags in reset", {tx_uf, rx_ovf}, 0);
  endtask

  task automatic t_disabled();
    int moves;
    moves = 0;
    cfg_en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclk || fs || sdo) moves++;
    end
    chk("R12", "pins active while disabled", moves, 0);
  endtask

  task automatic t_clock(input int div);
    realtime t1, t2;
    set_cfg(8, 1'b0, 1'b0, 40);
    cfg_half_div = 8'(div);
    @(negedge clk); cfg_en = 1'b1;
    @(posedge sclk); t1 = $realtime;
    @(posedge sclk); t2 = $realtime;
    chk("R4", "sclk period ps", longint'((t2 - t1) * 1000.0), longint'(div) * 2 * 5000);
    @(negedge clk); cfg_en = 1'b0;
    cfg_half_div = 8'd2;
  endtask

  task automatic t_word(input int len, input logic lsb, input logic [31:0] w);
    logic [31:0] got, rw;
    logic first;
    realtime tf;
    logic exp_first;
    set_cfg(len, lsb, 1'b0, 40);
    @(negedge clk); cfg_en = 1'b1;
    push_tx(w);
    grab(got, first, tf);
    chk("R1", $sformatf("word len %0d", len), got, w & wmask(len));
    exp_first = lsb ? w[0] : w[len-1];
    chk("R2", $sformatf("first bit len %0d lsb %0d", len, lsb), first, exp_first);
    idle(3);
    chk("R9", "rx_valid after frame", rx_valid, 1);
    pop_rx(rw);
    chk("R9", "received word", rw, w & wmask(len));
    idle(1);
    chk("R9", "rx empty after pop", rx_valid, 0);
  endtask

  task automatic t_dep_idle();
    int n;
    n = 0;
    repeat (30) begin
      @(posedge sclk);
      if (fs) n++;
    end
    chk("R6", "frames with empty queue", n, 0);
    chk("R7", "no underflow in data-driven mode", tx_uf, 0);
    @(negedge clk); cfg_en = 1'b0;
  endtask

  task automatic t_interval();
    logic [31:0] w1, w2, r;
    logic f;
    realtime t1, t2;
    int n;
    set_cfg(8, 1'b0, 1'b0, 11);
    push_tx(32'h5A);
    push_tx(32'hC3);
    chk("R8", "tx_full at two words", tx_full, 1);
    push_tx(32'h99);
    @(negedge clk); cfg_en = 1'b1;
    grab(w1, f, t1);
    grab(w2, f, t2);
    chk("R8", "first queued word", w1, 32'h5A);
    chk("R8", "second queued word", w2, 32'hC3);
    chk("R5", "frame spacing ps", longint'((t2 - t1) * 1000.0), 12 * 20000);
    n = 0;
    repeat (30) begin
      @(posedge sclk);
      if (fs) n++;
    end
    chk("R8", "frames from dropped write", n, 0);
    pop_rx(r);
    chk("R9", "rx oldest", r, 32'h5A);
    pop_rx(r);
    chk("R9", "rx second", r, 32'hC3);
    idle(1);
    chk("R9", "rx empty", rx_valid, 0);
    @(negedge clk); cfg_en = 1'b0;
  endtask

  task automatic t_underflow();
    logic [31:0] got, r;
    logic f;
    realtime t;
    set_cfg(8, 1'b0, 1'b0, 11);
    push_tx(32'hB4);
    cfg_free_fs = 1'b1;
    @(negedge clk); cfg_en = 1'b1;
    grab(got, f, t);
    idle(1);
    chk("R7", "first frame sends queued word", got, 32'hB4);
    chk("R7", "no underflow with data", tx_uf, 0);
    pop_rx(r);
    grab(got, f, t);
    idle(1);
    chk("R7", "resent word msb", got, 32'hB4);
    chk("R2", "resent first bit msb", f, 1);
    chk("R7", "underflow flagged", tx_uf, 1);
    cfg_lsb_first = 1'b1;
    pop_rx(r);
    chk("R9", "received resent word", r, 32'hB4);
    grab(got, f, t);
    idle(1);
    chk("R7", "resent word lsb order", got, 32'hB4);
    chk("R7", "resent first bit lsb", f, 0);
    @(negedge clk); clr_tx_uf = 1'b1;
    @(negedge clk); clr_tx_uf = 1'b0;
    chk("R11", "underflow cleared", tx_uf, 0);
    pop_rx(r);
    @(negedge clk); cfg_en = 1'b0;
    idle(2);
    while (rx_valid) pop_rx(r);
    @(negedge clk); clr_tx_uf = 1'b1;
    @(negedge clk); clr_tx_uf = 1'b0;
  endtask

  task automatic t_overflow();
    logic [31:0] got, r;
    logic f;
    realtime t;
    set_cfg(8, 1'b0, 1'b0, 11);
    push_tx(32'h11);
    push_tx(32'h22);
    cfg_free_fs = 1'b1;
    @(negedge clk); cfg_en = 1'b1;
    grab(got, f, t);
    grab(got, f, t);
    idle(2);
    chk("R10", "no overflow at two words", rx_ovf, 0);
    grab(got, f, t);
    idle(3);
    chk("R10", "overflow flagged", rx_ovf, 1);
    chk("R10", "head kept", rx_data, 32'h11);
    @(negedge clk); cfg_en = 1'b0;
    idle(2);
    pop_rx(r);
    chk("R10", "first kept word", r, 32'h11);
    pop_rx(r);
    chk("R10", "second kept word", r, 32'h22);
    idle(1);
    chk("R10", "third word dropped", rx_valid, 0);
    chk("R11", "overflow still set", rx_ovf, 1);
    @(negedge clk); clr_rx_ovf = 1'b1;
    @(negedge clk); clr_rx_ovf = 1'b0;
    chk("R11", "overflow cleared", rx_ovf, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_disabled();
    t_clock(3);
    t_clock(2);
    t_word(8, 1'b0, 32'hA5);
    t_word(13, 1'b1, 32'h1ABC);
    t_word(32, 1'b0, 32'hDEADBEEF);
    t_word(3, 1'b1, 32'h6);
    t_word(3, 1'b0, 32'h6);
    t_dep_idle();
    t_interval();
    t_underflow();
    t_overflow();
    t_disabled();
    report();
    $finish;
  end
endmodule